// File: doc/BRIEF.md
# Framed PCM Serial Port

This block is the digital half of a single-channel voice codec's serial link. It runs on a free-running system clock. The external bit clock, the two frame syncs, the serial receive data and the power-down pin are all sampled into that clock domain. Edges are then detected on the sampled copies.

On the transmit side, an 8-bit companded sample is captured from a parallel input at each transmit sync rise. The sample is shifted out most significant bit first through an open-drain style output, which is modelled as a pull-low request and an output enable. On the receive side, the port aligns to its own receive sync, collects eight bits on the falling edges of the bit clock, and presents the word with a one-cycle strobe.

The port watches the bit clock and both syncs for activity. If any of them stops toggling for longer than a programmable number of system clocks, the port falls into power-save. A low level on the power-down pin forces power-down. From either state, the port returns to normal operation only after clean frames have resumed.

Top module: `pcm_serial_port`

## Requirements
- R1: Receive bits are taken on falling bit-clock edges, most significant bit first. When the eighth bit of a frame is taken, the word appears on `rx_word` and `rx_valid` is high for exactly one system clock.
- R2: A receive frame begins at the rising edge of `rsync`. A new `rsync` rise before eight bits have been taken discards the partial word, and no `rx_valid` is given for it.
- R3: Transmit bits leave most significant bit first, one bit per rising bit-clock edge, eight bits per frame. The word is captured from `tx_word` at the transmit sync rise, so later changes to `tx_word` do not alter the frame.
- R4: The first transmit bit depends on the bit-clock level when `xsync` rises. If the bit clock is high (within half a period after its rising edge), the first bit is launched at the sync edge. Otherwise it is launched at the next rising bit-clock edge.
- R5: `txd_oe` is high only during the eight-bit window, which closes at the ninth rising bit-clock edge of the frame. `txd_low` is high exactly when `txd_oe` is high and the current bit is 0.
- R6: If `bclk`, `xsync` or `rsync` shows no edge for more than `stall_limit` system clocks, `port_mode` becomes 2'b01 (power-save). While in power-save, `txd_oe` stays low and `rx_valid` is never given.
- R7: A low `pdn_n` puts `port_mode` at 2'b10 (power-down). This has priority over power-save, and both paths stay idle.
- R8: After reset, and after leaving power-down, the port is in power-save. It becomes active (`port_mode` 2'b00) at the second transmit sync rise seen with no stalled input. The frame started by that rise is neither sent nor received.
- R9: A transmit sync rise in the middle of a frame restarts transmission with a newly captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_limit | input | 16 | Quiet time in system clocks after which an input counts as stalled |
| bclk | input | 1 | External serial bit clock |
| xsync | input | 1 | Transmit frame sync |
| rsync | input | 1 | Receive frame sync |
| pdn_n | input | 1 | Power-down request, active low |
| rxd | input | 1 | Serial receive data |
| tx_word | input | 8 | Sample to send in the next transmit frame |
| txd_low | output | 1 | Pull the open-drain line low (current bit is 0) |
| txd_oe | output | 1 | Transmit window active; line is released when low |
| rx_word | output | 8 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_word` |
| port_mode | output | 2 | 2'b00 active, 2'b01 power-save, 2'b10 power-down |

## Verification
The assertions assume the following about the inputs:
- Every bit-clock phase spans several system clocks, so two edges of the same input never appear in adjacent cycles.
- `rxd` only changes near rising bit-clock edges, so it is settled at each falling edge.
- The sync period stays below `stall_limit`.

The stimulus meets these assumptions by driving every input on the falling system-clock edge, with bit-clock phases of 4 to 8 system clocks and `rxd` updated together with each bit-clock rise. Frames are at most 14 bit clocks long, against a limit of 300.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_SAVE   = 2'b01,
    PM_DOWN   = 2'b10
  } port_mode_e;

  // Index of each monitored line inside the synchronizer vector
  localparam int unsigned IDX_BCLK = 0;
  localparam int unsigned IDX_XS   = 1;
  localparam int unsigned IDX_RS   = 2;
  localparam int unsigned IDX_RXD  = 3;
  localparam int unsigned IDX_PDN  = 4;
  localparam int unsigned N_IN     = 5;
  localparam int unsigned N_MON    = 3;

endpackage

// File: rtl/pcm_sync_vec.sv
module pcm_sync_vec #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/pcm_stall_mon.sv
module pcm_stall_mon #(
  parameter int unsigned TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            edge_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            stalled_o
);

  logic [TO_W-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                quiet_q <= '0;
    else if (edge_i)           quiet_q <= '0;
    else if (quiet_q != '1)    quiet_q <= quiet_q + 1'b1;
  end

  // An edge in this cycle overrides an old stall immediately
  assign stalled_o = (quiet_q > limit_i) && !edge_i;

  AST_STALL_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stalled_o |-> !$past(edge_i)); // R6

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active_i,
  input  logic         bclk_lvl_i,
  input  logic         bclk_rise_i,
  input  logic         sync_rise_i,
  input  logic [W-1:0] word_i,
  output logic         oe_o,
  output logic         bit_o
);

  localparam int unsigned IW = $clog2(W + 1);
  localparam logic [IW-1:0] LAST = IW'(W);

  logic [W-1:0]  sr_q;
  logic [IW-1:0] idx_q;
  logic          oe_q;
  logic          pend_q;

  function automatic logic [W-1:0] next_bit_word(input logic [W-1:0] cur);
    return {cur[W-2:0], 1'b0};
  endfunction

  // Sync edge while the bit clock is still high => immediate launch
  function automatic logic launch_on_sync(input logic bclk_high);
    return bclk_high;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      idx_q  <= '0;
      oe_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (!active_i) begin
      idx_q  <= '0;
      oe_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (sync_rise_i) begin
      sr_q <= word_i;
      if (launch_on_sync(bclk_lvl_i)) begin
        oe_q   <= 1'b1;
        idx_q  <= IW'(1);
        pend_q <= 1'b0;
      end else begin
        oe_q   <= 1'b0;
        idx_q  <= '0;
        pend_q <= 1'b1;
      end
    end else if (bclk_rise_i) begin
      if (pend_q) begin
        oe_q   <= 1'b1;
        idx_q  <= IW'(1);
        pend_q <= 1'b0;
      end else if (oe_q) begin
        if (idx_q == LAST) begin
          oe_q <= 1'b0;
        end else begin
          sr_q  <= next_bit_word(sr_q);
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign oe_o  = oe_q;
  assign bit_o = sr_q[W-1];

  AST_TX_IDLE_WHEN_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> !oe_o); // R5

  AST_TX_BIT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && $past(oe_o) && (bit_o != $past(bit_o))) |-> ($past(bclk_rise_i) || $past(sync_rise_i))); // R3

  AST_TX_SYNC_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && sync_rise_i && bclk_lvl_i) |=> oe_o); // R4

  AST_TX_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST); // R5

endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active_i,
  input  logic         bclk_fall_i,
  input  logic         sync_rise_i,
  input  logic         din_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);

  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr_q;
  logic [W-1:0]  word_q;
  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          valid_q;

  function automatic logic [W-1:0] take_bit(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!active_i) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (sync_rise_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (bclk_fall_i && armed_q) begin
        sr_q <= take_bit(sr_q, din_i);
        if (cnt_q == LAST) begin
          word_q  <= take_bit(sr_q, din_i);
          valid_q <= 1'b1;
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  AST_RX_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(bclk_fall_i)); // R1

  AST_RX_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R1

  AST_RX_NO_VALID_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(active_i)); // R6

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned WORD_W        = 8,
  parameter int unsigned TO_W          = 16,
  parameter int unsigned RECOVER_SYNCS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TO_W-1:0]   stall_limit,
  input  logic              bclk,
  input  logic              xsync,
  input  logic              rsync,
  input  logic              pdn_n,
  input  logic              rxd,
  input  logic [WORD_W-1:0] tx_word,
  output logic              txd_low,
  output logic              txd_oe,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic [1:0]        port_mode
);

  localparam int unsigned RW = $clog2(RECOVER_SYNCS + 1);
  localparam logic [RW-1:0] REC_LAST = RW'(RECOVER_SYNCS - 1);
  localparam logic [N_IN-1:0] SYNC_RST = N_IN'(1) << IDX_PDN;

  // ---------------- input synchronizers ----------------
  logic [N_IN-1:0]  raw_in;
  logic [N_IN-1:0]  lvl;
  logic [N_MON-1:0] prev_q;
  logic [N_MON-1:0] mon_edge;

  assign raw_in[IDX_BCLK] = bclk;
  assign raw_in[IDX_XS]   = xsync;
  assign raw_in[IDX_RS]   = rsync;
  assign raw_in[IDX_RXD]  = rxd;
  assign raw_in[IDX_PDN]  = pdn_n;

  pcm_sync_vec #(.W(N_IN), .RST_VAL(SYNC_RST)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_in),
    .sync_o  (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl[N_MON-1:0];
  end

  assign mon_edge = lvl[N_MON-1:0] ^ prev_q;

  // Named edge events
  logic bclk_rise, bclk_fall, xs_rise, rs_rise, pdn_lvl, rxd_lvl;
  assign bclk_rise = lvl[IDX_BCLK] & ~prev_q[IDX_BCLK];
  assign bclk_fall = ~lvl[IDX_BCLK] & prev_q[IDX_BCLK];
  assign xs_rise   = lvl[IDX_XS] & ~prev_q[IDX_XS];
  assign rs_rise   = lvl[IDX_RS] & ~prev_q[IDX_RS];
  assign pdn_lvl   = lvl[IDX_PDN];
  assign rxd_lvl   = lvl[IDX_RXD];

  // ---------------- stall monitors ----------------
  logic [N_MON-1:0] stalled;
  logic             any_stall;

  for (genvar g = 0; g < N_MON; g++) begin : g_mon
    pcm_stall_mon #(.TO_W(TO_W)) i_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_i    (mon_edge[g]),
      .limit_i   (stall_limit),
      .stalled_o (stalled[g])
    );
  end

  assign any_stall = |stalled;

  // ---------------- power mode control ----------------
  port_mode_e    mode_q;
  logic [RW-1:0] rec_q;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_SAVE;
      rec_q  <= '0;
    end else begin
      unique case (mode_q)
        PM_ACTIVE: begin
          if (!pdn_lvl) begin
            mode_q <= PM_DOWN;
          end else if (any_stall) begin
            mode_q <= PM_SAVE;
            rec_q  <= '0;
          end
        end
        PM_SAVE: begin
          if (!pdn_lvl) begin
            mode_q <= PM_DOWN;
            rec_q  <= '0;
          end else if (any_stall) begin
            rec_q <= '0;
          end else if (xs_rise) begin
            if (rec_q == REC_LAST) begin
              mode_q <= PM_ACTIVE;
              rec_q  <= '0;
            end else begin
              rec_q <= rec_q + 1'b1;
            end
          end
        end
        default: begin
          if (pdn_lvl) begin
            mode_q <= PM_SAVE;
            rec_q  <= '0;
          end
        end
      endcase
    end
  end

  assign active    = (mode_q == PM_ACTIVE);
  assign port_mode = mode_q;

  // ---------------- data paths ----------------
  logic tx_bit;

  pcm_tx_shifter #(.W(WORD_W)) i_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active),
    .bclk_lvl_i  (lvl[IDX_BCLK]),
    .bclk_rise_i (bclk_rise),
    .sync_rise_i (xs_rise),
    .word_i      (tx_word),
    .oe_o        (txd_oe),
    .bit_o       (tx_bit)
  );

  assign txd_low = txd_oe & ~tx_bit;

  pcm_rx_shifter #(.W(WORD_W)) i_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active),
    .bclk_fall_i (bclk_fall),
    .sync_rise_i (rs_rise),
    .din_i       (rxd_lvl),
    .word_o      (rx_word),
    .valid_o     (rx_valid)
  );

  AST_PDN_FORCES_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_lvl |=> (port_mode == PM_DOWN)); // R7

  AST_STALL_LEAVES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn_lvl && any_stall) |=> (port_mode != PM_ACTIVE)); // R6

  AST_ACTIVE_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    ((port_mode == PM_ACTIVE) && ($past(port_mode) != PM_ACTIVE)) |-> $past(xs_rise)); // R8

  AST_DOWN_EXITS_TO_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(port_mode) == PM_DOWN) && (port_mode != PM_DOWN)) |-> (port_mode == PM_SAVE)); // R8

endmodule

// File: tb/test_pcm_serial_port.sv
`timescale 1ns/1ps
module test_pcm_serial_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] stall_limit = 16'd300;
  logic        bclk = 1'b0, xsync = 1'b0, rsync = 1'b0, pdn_n = 1'b1, rxd = 1'b0;
  logic [7:0]  tx_word = 8'h00;
  logic        txd_low, txd_oe, rx_valid;
  logic [7:0]  rx_word;
  logic [1:0]  port_mode;

  int n_checks = 0;
  int n_fail   = 0;
  int vcnt     = 0;
  logic [7:0] last_rx = 8'h00;

  always #2.5 clk = ~clk;

  pcm_serial_port i_pcm_serial_port (
    .clk(clk), .rst_n(rst_n), .stall_limit(stall_limit),
    .bclk(bclk), .xsync(xsync), .rsync(rsync), .pdn_n(pdn_n), .rxd(rxd),
    .tx_word(tx_word), .txd_low(txd_low), .txd_oe(txd_oe),
    .rx_word(rx_word), .rx_valid(rx_valid), .port_mode(port_mode)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      vcnt    = vcnt + 1;
      last_rx = rx_word;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // Free bit clock with no syncs
  task automatic bclk_run(input int h, input int n);
    for (int i = 0; i < n; i++) begin
      bclk = 1'b1; repeat (h) @(negedge clk);
      bclk = 1'b0; repeat (h) @(negedge clk);
    end
  endtask

  // One frame: preamble low phase, then nb bit-clock periods.
  // sl=1: xsync rises just after the first bit-clock rise (sync launch).
  task automatic frame(input int h, input int nb, input bit sl, input logic [7:0] tw,
                       input logic [7:0] rw, input bit act, input bit pre, input string tag);
    int v0;
    logic eb;
    v0 = vcnt;
    tx_word = tw;
    if (pre) chk(txd_oe == 1'b0, {"R5 oe before sync ", tag}, txd_oe, 0);
    repeat (h / 2) @(negedge clk);
    rsync = 1'b1;
    if (!sl) xsync = 1'b1;
    repeat (h - h / 2) @(negedge clk);
    for (int k = 1; k <= nb; k++) begin
      bclk = 1'b1;
      rxd  = (k <= 8) ? rw[8 - k] : 1'b0;
      if (k == 2) begin xsync = 1'b0; rsync = 1'b0; end
      if (k == 1 && sl) begin
        @(negedge clk); xsync = 1'b1; repeat (h - 1) @(negedge clk);
      end else begin
        repeat (h) @(negedge clk);
      end
      if (k == 1) tx_word = ~tw;   // R3: must not disturb the frame
      bclk = 1'b0;
      repeat (h) @(negedge clk);
      if (act && k <= 8) begin
        eb = tw[8 - k];
        chk(txd_oe == 1'b1, {"R3 R4 oe in window ", tag}, txd_oe, 1);
        chk(txd_low == ~eb, {"R3 R4 tx bit ", tag}, txd_low, int'(~eb));
      end else begin
        chk(txd_oe == 1'b0 && txd_low == 1'b0, {"R5 R6 oe outside window ", tag}, txd_oe, 0);
      end
    end
    if (act && nb >= 8) begin
      chk(vcnt - v0 == 1, {"R1 one rx_valid ", tag}, vcnt - v0, 1);
      chk(last_rx == rw, {"R1 rx_word ", tag}, last_rx, rw);
      chk(port_mode == 2'b00, {"R8 mode active ", tag}, port_mode, 0);
    end else begin
      chk(vcnt == v0, {"R2 R6 no rx_valid ", tag}, vcnt - v0, 0);
    end
  endtask

  task automatic recover(input int h);
    bclk_run(h, 4);
    frame(h, 10, 1'b0, 8'h11, 8'h22, 1'b0, 1'b1, "R8 recovery 1");
    frame(h, 10, 1'b0, 8'h33, 8'h44, 1'b0, 1'b1, "R8 recovery 2");
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(txd_oe == 1'b0, "R5 reset oe", txd_oe, 0);
    chk(rx_valid == 1'b0, "R1 reset valid", rx_valid, 0);
    chk(port_mode == 2'b01, "R8 reset mode save", port_mode, 1);
  endtask

  task automatic t_launch_cases();
    recover(6);
    frame(6, 10, 1'b0, 8'hA5, 8'h3C, 1'b1, 1'b1, "R4 clock launch");
    frame(6, 10, 1'b1, 8'h5A, 8'hC3, 1'b1, 1'b1, "R4 sync launch");
    frame(6, 10, 1'b0, 8'h00, 8'hFF, 1'b1, 1'b1, "R3 zeros");
    frame(6, 10, 1'b1, 8'hFF, 8'h00, 1'b1, 1'b1, "R3 ones");
  endtask

  task automatic t_ratios();
    frame(4, 10, 1'b0, 8'h81, 8'h7E, 1'b1, 1'b1, "R1 ratio 4");
    frame(4, 9,  1'b1, 8'h69, 8'h96, 1'b1, 1'b1, "R3 ratio 4 sync");
    frame(8, 14, 1'b0, 8'h2B, 8'hD4, 1'b1, 1'b1, "R1 ratio 8");
    frame(5, 12, 1'b1, 8'hC7, 8'h38, 1'b1, 1'b1, "R4 ratio 5 sync");
  endtask

  task automatic t_restart();
    frame(6, 4,  1'b0, 8'hF0, 8'h0F, 1'b1, 1'b1, "R2 R9 partial clk");
    frame(6, 10, 1'b0, 8'h4E, 8'hB1, 1'b1, 1'b0, "R2 R9 restarted clk");
    frame(6, 4,  1'b1, 8'h99, 8'h66, 1'b1, 1'b1, "R2 R9 partial sync");
    frame(6, 10, 1'b1, 8'h17, 8'hE8, 1'b1, 1'b0, "R2 R9 restarted sync");
  endtask

  task automatic t_stall_clock();
    repeat (400) @(negedge clk);
    chk(port_mode == 2'b01, "R6 bclk stall save", port_mode, 1);
    chk(txd_oe == 1'b0, "R6 bclk stall oe", txd_oe, 0);
    recover(6);
    frame(6, 10, 1'b0, 8'h3D, 8'hA2, 1'b1, 1'b1, "R8 after clock stall");
  endtask

  task automatic t_stall_sync();
    bclk_run(4, 60);
    chk(port_mode == 2'b01, "R6 sync stall save", port_mode, 1);
    frame(6, 10, 1'b0, 8'h55, 8'hAA, 1'b0, 1'b1, "R6 idle in save");
    frame(6, 10, 1'b0, 8'h55, 8'hAA, 1'b0, 1'b1, "R8 second clean sync");
    frame(6, 10, 1'b1, 8'hE1, 8'h1E, 1'b1, 1'b1, "R8 after sync stall");
  endtask

  task automatic t_pdn();
    pdn_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(port_mode == 2'b10, "R7 pdn mode", port_mode, 2);
    frame(6, 10, 1'b0, 8'h42, 8'h24, 1'b0, 1'b1, "R7 idle in pdn");
    chk(port_mode == 2'b10, "R7 pdn held", port_mode, 2);
    repeat (400) @(negedge clk);
    chk(port_mode == 2'b10, "R7 pdn over stall", port_mode, 2);
    pdn_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(port_mode == 2'b01, "R8 pdn exit to save", port_mode, 1);
    recover(6);
    frame(6, 10, 1'b0, 8'h8C, 8'h73, 1'b1, 1'b1, "R8 after pdn");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..R9: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_launch_cases();
    t_ratios();
    t_restart();
    t_stall_clock();
    t_stall_sync();
    t_pdn();
    summary();
    $finish;
  end

endmodule